// File: doc/BRIEF.md
# Load-Store Ordering Queue with Store Forwarding

This block keeps every in-flight memory access of an out-of-order core in program order. An entry is allocated at issue, and the core learns its index. Addresses and store data arrive later, in any order, through two fill ports that name the entry. The queue then decides for each load whether it may go to memory, may take its value straight from an older store still held in the queue, or must wait.

A load waits while any older store has no address yet. When older stores with a known address match the load, the youngest of them supplies the value, and that value goes out on the result port with a forwarded flag. If that store has no data yet, the load waits for it. When every older store is known to go elsewhere, the load is sent to memory. It does not wait for those stores to be written. Stores drain strictly from the head of the queue, one per accepted memory request. Loads retire from the head once their value has been delivered. A flush empties the queue in one cycle.

Top module: `lsq_fwd_queue`

## Requirements
- R1: After reset, `full` is low, `mem_req_valid` and `ld_res_valid` are low, and `alloc_idx` is 0.
- R2: Entries are allocated in program order. `alloc_idx` names the entry the next allocation takes and steps by one modulo DEPTH on each accepted allocation. `full` is high while DEPTH entries are held. An allocation requested while `full` is high is ignored and does not move `alloc_idx`.
- R3: A load with a known address sends no memory request and produces no result while any older store has no address. The load stays held even if another older store matches.
- R4: When all older stores have known addresses that differ from the load address, the load issues a read request (`mem_req_write`=0, its index and address). It does so even if those stores have not yet been written.
- R5: When an older store with data has the same address as the load, the load result carries that store's data with `ld_res_fwd`=1, and the load never issues a memory read.
- R6: When several older stores match the load address, the forwarded data is that of the youngest of them.
- R7: A load whose youngest matching older store has no data yet produces no result and no request until that data is filled. It then completes by forwarding.
- R8: Stores younger than a load never affect that load's result, even when their address matches.
- R9: A store is written (`mem_req_write`=1) only when it is the oldest entry and has both address and data. Stores are written in program order, one per cycle while `mem_req_ready` is high. While `mem_req_ready` is low, the write request is held with unchanged address and data.
- R10: A memory read response is returned one cycle later on the load result port. It carries the response data, the entry index given with the response, and `ld_res_fwd`=0.
- R11: A flush empties the queue. In the next cycle `full` is low, `alloc_idx` is 0 and no memory request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every entry and reset the pointers |
| alloc_valid | input | 1 | Allocation request at issue |
| alloc_is_store | input | 1 | 1 for a store, 0 for a load |
| alloc_idx | output | IW | Entry index the next allocation receives |
| full | output | 1 | All DEPTH entries are held; allocation stalls |
| addr_valid | input | 1 | Address fill strobe |
| addr_idx | input | IW | Entry receiving the address |
| addr_value | input | AW | Address value |
| data_valid | input | 1 | Store data fill strobe |
| data_idx | input | IW | Store entry receiving the data |
| data_value | input | DW | Store data value |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 for a store write, 0 for a load read |
| mem_req_idx | output | IW | Entry index of the request |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data (0 for reads) |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_idx | input | IW | Load entry the response belongs to |
| mem_rsp_data | input | DW | Read data |
| ld_res_valid | output | 1 | Load result present |
| ld_res_idx | output | IW | Load entry of the result |
| ld_res_data | output | DW | Load value |
| ld_res_fwd | output | 1 | 1 when the value came from a queued store |

## Verification
The assertions assume a well-behaved core and memory. Fills only name entries allocated in an earlier cycle and are given once per entry. Each read response names a load whose request was accepted and that has not completed. No flush happens while a read is outstanding. The bench keeps to these assumptions: every address and data value is filled exactly once, its memory model answers one cycle after each accepted read, and each scenario waits for all results before it flushes. Scenarios that need a store to stay in the queue hold `mem_req_ready` low, and forwarding and stalling are observed under that condition.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

   // Per-load decision made every cycle
   typedef enum logic [2:0] {
      LD_IDLE      = 3'd0,  // not a pending load with an address
      LD_WAIT_ADDR = 3'd1,  // an older store has no address yet
      LD_WAIT_DATA = 3'd2,  // youngest matching older store lacks data
      LD_FWD       = 3'd3,  // value can be taken from a queued store
      LD_MEM       = 3'd4   // no conflict, may read memory
   } ld_disp_e;

   function automatic ld_disp_e decide(input logic cand, input logic blk,
                                       input logic hit, input logic hit_dok);
      if (!cand)        return LD_IDLE;
      else if (blk)     return LD_WAIT_ADDR;
      else if (!hit)    return LD_MEM;
      else if (!hit_dok) return LD_WAIT_DATA;
      else              return LD_FWD;
   endfunction

endpackage

// File: rtl/lsq_order_check.sv
// Scans the entries older than one load slot, walking from the head.
module lsq_order_check #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int SELF  = 0,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]         vld,
   input  logic [DEPTH-1:0]         st,
   input  logic [DEPTH-1:0]         aok,
   input  logic [DEPTH-1:0]         dok,
   input  logic [DEPTH-1:0][AW-1:0] addr,
   input  logic [IW-1:0]            head,
   output logic                     blk,
   output logic                     hit,
   output logic [IW-1:0]            hit_idx,
   output logic                     hit_dok
);

   logic [IW-1:0] self_rel;
   assign self_rel = IW'(SELF) - head;

   always_comb begin
      logic [IW-1:0] j;
      blk     = 1'b0;
      hit     = 1'b0;
      hit_idx = '0;
      hit_dok = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
         j = head + IW'(k);
         if (IW'(k) < self_rel && vld[j] && st[j]) begin
            if (!aok[j]) begin
               blk = 1'b1;
            end else if (addr[j] == addr[SELF]) begin
               // later iterations are younger: last match wins
               hit     = 1'b1;
               hit_idx = j;
               hit_dok = dok[j];
            end
         end
      end
   end

endmodule

// File: rtl/lsq_oldest_pick.sv
// Picks the oldest requesting slot, counting age from the head pointer.
module lsq_oldest_pick #(
   parameter int DEPTH = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] req,
   input  logic [IW-1:0]    head,
   output logic             found,
   output logic [IW-1:0]    idx
);

   always_comb begin
      logic [IW-1:0] j;
      found = 1'b0;
      idx   = '0;
      for (int k = 0; k < DEPTH; k++) begin
         j = head + IW'(k);
         if (!found && req[j]) begin
            found = 1'b1;
            idx   = j;
         end
      end
   end

endmodule

// File: rtl/lsq_fwd_queue.sv
module lsq_fwd_queue
   import lsq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int DW    = 32,
   localparam int IW   = $clog2(DEPTH),
   localparam int CW   = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          alloc_valid,
   input  logic          alloc_is_store,
   output logic [IW-1:0] alloc_idx,
   output logic          full,
   input  logic          addr_valid,
   input  logic [IW-1:0] addr_idx,
   input  logic [AW-1:0] addr_value,
   input  logic          data_valid,
   input  logic [IW-1:0] data_idx,
   input  logic [DW-1:0] data_value,
   output logic          mem_req_valid,
   output logic          mem_req_write,
   output logic [IW-1:0] mem_req_idx,
   output logic [AW-1:0] mem_req_addr,
   output logic [DW-1:0] mem_req_wdata,
   input  logic          mem_req_ready,
   input  logic          mem_rsp_valid,
   input  logic [IW-1:0] mem_rsp_idx,
   input  logic [DW-1:0] mem_rsp_data,
   output logic          ld_res_valid,
   output logic [IW-1:0] ld_res_idx,
   output logic [DW-1:0] ld_res_data,
   output logic          ld_res_fwd
);

   // elaboration-time parameter checks
   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("lsq_fwd_queue: DEPTH must be a power of two, at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("lsq_fwd_queue: AW and DW must be positive");
   end

   // entry state
   logic [DEPTH-1:0]         vld_q, st_q, aok_q, dok_q, iss_q, dn_q;
   logic [DEPTH-1:0][AW-1:0] addr_q;
   logic [DEPTH-1:0][DW-1:0] data_q;
   logic [IW-1:0]            head_q, tail_q;
   logic [CW-1:0]            count_q;

   // per-load ordering results
   logic [DEPTH-1:0]          blk, hit, hit_dok, fwd_req, mem_ld_req;
   logic [DEPTH-1:0][IW-1:0]  hit_idx;
   ld_disp_e                  disp [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      lsq_order_check #(.DEPTH(DEPTH), .AW(AW), .SELF(g)) u_chk (
         .vld     (vld_q),
         .st      (st_q),
         .aok     (aok_q),
         .dok     (dok_q),
         .addr    (addr_q),
         .head    (head_q),
         .blk     (blk[g]),
         .hit     (hit[g]),
         .hit_idx (hit_idx[g]),
         .hit_dok (hit_dok[g])
      );
      assign disp[g] = decide(vld_q[g] && !st_q[g] && aok_q[g] && !iss_q[g] && !dn_q[g],
                              blk[g], hit[g], hit_dok[g]);
      assign fwd_req[g]    = (disp[g] == LD_FWD);
      assign mem_ld_req[g] = (disp[g] == LD_MEM);
   end

   // selection among candidates, oldest first
   logic          fwd_found, ld_found;
   logic [IW-1:0] fwd_idx, ld_idx;

   lsq_oldest_pick #(.DEPTH(DEPTH)) u_fwd_pick (
      .req (fwd_req), .head (head_q), .found (fwd_found), .idx (fwd_idx));
   lsq_oldest_pick #(.DEPTH(DEPTH)) u_ld_pick (
      .req (mem_ld_req), .head (head_q), .found (ld_found), .idx (ld_idx));

   // memory request: a complete store at the head goes before any read
   logic head_store_ok;
   assign head_store_ok = vld_q[head_q] && st_q[head_q] && aok_q[head_q] && dok_q[head_q];

   assign mem_req_valid = head_store_ok || ld_found;
   assign mem_req_write = head_store_ok;
   assign mem_req_idx   = head_store_ok ? head_q : ld_idx;
   assign mem_req_addr  = addr_q[mem_req_idx];
   assign mem_req_wdata = head_store_ok ? data_q[head_q] : '0;

   logic mem_fire, st_write, ld_issue, fwd_take, retire, alloc_fire;
   assign mem_fire   = mem_req_valid && mem_req_ready;
   assign st_write   = mem_fire && head_store_ok;
   assign ld_issue   = mem_fire && !head_store_ok;
   assign fwd_take   = fwd_found && !mem_rsp_valid;
   assign retire     = st_write || (vld_q[head_q] && !st_q[head_q] && dn_q[head_q]);
   assign full       = (count_q == CW'(DEPTH));
   assign alloc_fire = alloc_valid && !full;
   assign alloc_idx  = tail_q;

   // pointers and occupancy
   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (alloc_fire) tail_q <= tail_q + 1'b1;
         if (retire)     head_q <= head_q + 1'b1;
         count_q <= count_q + CW'(alloc_fire) - CW'(retire);
      end
   end

   // entry fields
   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         vld_q  <= '0;
         st_q   <= '0;
         aok_q  <= '0;
         dok_q  <= '0;
         iss_q  <= '0;
         dn_q   <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (alloc_fire && tail_q == IW'(i)) begin
               vld_q[i] <= 1'b1;
               st_q[i]  <= alloc_is_store;
               aok_q[i] <= 1'b0;
               dok_q[i] <= 1'b0;
               iss_q[i] <= 1'b0;
               dn_q[i]  <= 1'b0;
            end
            if (addr_valid && addr_idx == IW'(i)) begin
               aok_q[i]  <= 1'b1;
               addr_q[i] <= addr_value;
            end
            if (data_valid && data_idx == IW'(i)) begin
               dok_q[i]  <= 1'b1;
               data_q[i] <= data_value;
            end
            if (ld_issue && ld_idx == IW'(i))
               iss_q[i] <= 1'b1;
            if ((mem_rsp_valid && mem_rsp_idx == IW'(i)) ||
                (fwd_take && fwd_idx == IW'(i)))
               dn_q[i] <= 1'b1;
            if (retire && head_q == IW'(i))
               vld_q[i] <= 1'b0;
         end
      end
   end

   // load result register: a memory response wins over a forward
   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         ld_res_valid <= 1'b0;
         ld_res_idx   <= '0;
         ld_res_data  <= '0;
         ld_res_fwd   <= 1'b0;
      end else begin
         ld_res_valid <= mem_rsp_valid || fwd_take;
         if (mem_rsp_valid) begin
            ld_res_idx  <= mem_rsp_idx;
            ld_res_data <= mem_rsp_data;
            ld_res_fwd  <= 1'b0;
         end else if (fwd_take) begin
            ld_res_idx  <= fwd_idx;
            ld_res_data <= data_q[hit_idx[fwd_idx]];
            ld_res_fwd  <= 1'b1;
         end
      end
   end

   // ---------------- assertions ----------------
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));

   a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (full && alloc_valid && !flush) |=> $stable(alloc_idx));

   // R3 and R5: a read is only sent for a load with no blocking or matching store
   a_r3_load_req_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> (!blk[mem_req_idx] && !hit[mem_req_idx]));

   a_r9_write_complete: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |->
         (st_q[mem_req_idx] && aok_q[mem_req_idx] && dok_q[mem_req_idx] && count_q != '0));

   a_r9_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write && !mem_req_ready && !flush) |=>
         (mem_req_valid && mem_req_write && $stable(mem_req_addr) && $stable(mem_req_wdata)));

   a_r10_rsp_result: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && !flush) |=>
         (ld_res_valid && !ld_res_fwd && ld_res_idx == $past(mem_rsp_idx)));

   a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!full && !mem_req_valid && alloc_idx == '0));

endmodule

// File: tb/sim_lsq_fwd_queue.sv
`timescale 1ns/1ps
module sim_lsq_fwd_queue;

   localparam int DEPTH = 8;
   localparam int AW    = 16;
   localparam int DW    = 32;
   localparam int IW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          alloc_valid = 1'b0, alloc_is_store = 1'b0;
   logic [IW-1:0] alloc_idx;
   logic          full;
   logic          addr_valid = 1'b0;
   logic [IW-1:0] addr_idx = '0;
   logic [AW-1:0] addr_value = '0;
   logic          data_valid = 1'b0;
   logic [IW-1:0] data_idx = '0;
   logic [DW-1:0] data_value = '0;
   logic          mem_req_valid, mem_req_write;
   logic [IW-1:0] mem_req_idx;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_wdata;
   logic          mem_req_ready = 1'b1;
   logic          mem_rsp_valid = 1'b0;
   logic [IW-1:0] mem_rsp_idx = '0;
   logic [DW-1:0] mem_rsp_data = '0;
   logic          ld_res_valid, ld_res_fwd;
   logic [IW-1:0] ld_res_idx;
   logic [DW-1:0] ld_res_data;

   always #2 clk = ~clk;

   lsq_fwd_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (.*);

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // memory model, result monitor and logs (all at the falling edge)
   logic [DW-1:0] wmem  [256];
   bit            wflag [256];
   int            cyc = 0;
   int            rd_n = 0, wr_n = 0, res_n = 0;
   logic [AW-1:0] wr_addr [64];
   logic [DW-1:0] wr_data [64];
   int            wr_cyc  [64];
   int            res_ser [DEPTH];
   logic [DW-1:0] res_dat [DEPTH];
   logic          res_fw  [DEPTH];
   bit            pend_v = 1'b0;
   logic [IW-1:0] pend_idx = '0;
   logic [DW-1:0] pend_dat = '0;

   function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
      return 32'hC0DE_0000 | 32'(a);
   endfunction

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) wflag[i] = 1'b0;
         for (int i = 0; i < DEPTH; i++) res_ser[i] = 0;
      end
      if (ld_res_valid) begin
         res_n++;
         res_ser[ld_res_idx] = res_n;
         res_dat[ld_res_idx] = ld_res_data;
         res_fw[ld_res_idx]  = ld_res_fwd;
      end
      mem_rsp_valid = pend_v;
      mem_rsp_idx   = pend_idx;
      mem_rsp_data  = pend_dat;
      pend_v = 1'b0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            wmem[mem_req_addr[7:0]]  = mem_req_wdata;
            wflag[mem_req_addr[7:0]] = 1'b1;
            if (wr_n < 64) begin
               wr_addr[wr_n] = mem_req_addr;
               wr_data[wr_n] = mem_req_wdata;
               wr_cyc[wr_n]  = cyc;
            end
            wr_n++;
         end else begin
            pend_v   = 1'b1;
            pend_idx = mem_req_idx;
            pend_dat = wflag[mem_req_addr[7:0]] ? wmem[mem_req_addr[7:0]]
                                                : init_val(mem_req_addr);
            rd_n++;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic alloc(input logic is_st, output logic [IW-1:0] idx);
      alloc_valid    = 1'b1;
      alloc_is_store = is_st;
      idx            = alloc_idx;
      tick();
      alloc_valid = 1'b0;
   endtask

   task automatic put_addr(input logic [IW-1:0] i, input logic [AW-1:0] a);
      addr_valid = 1'b1; addr_idx = i; addr_value = a;
      tick();
      addr_valid = 1'b0;
   endtask

   task automatic put_data(input logic [IW-1:0] i, input logic [DW-1:0] d);
      data_valid = 1'b1; data_idx = i; data_value = d;
      tick();
      data_valid = 1'b0;
   endtask

   task automatic do_flush();
      flush = 1'b1;
      tick();
      flush = 1'b0;
   endtask

   task automatic close_case();
      mem_req_ready = 1'b1;
      wait_cyc(12);
      do_flush();
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1 full", 32'(full), 0);
      chk("R1 mem_req_valid", 32'(mem_req_valid), 0);
      chk("R1 ld_res_valid", 32'(ld_res_valid), 0);
      chk("R1 alloc_idx", 32'(alloc_idx), 0);
   endtask

   task automatic t_plain_load();
      logic [IW-1:0] l0;
      int rb = rd_n, sb = res_n;
      mem_req_ready = 1'b1;
      alloc(1'b0, l0);
      put_addr(l0, 16'h0010);
      wait_cyc(6);
      chk("R10 result seen", 32'(res_ser[l0] > sb), 1);
      chk("R10 result data", res_dat[l0], init_val(16'h0010));
      chk("R10 result fwd flag", 32'(res_fw[l0]), 0);
      chk("R4 one read", 32'(rd_n - rb), 1);
      close_case();
   endtask

   task automatic t_unknown_addr();
      logic [IW-1:0] s0, l1;
      int rb = rd_n, wb = wr_n, sb = res_n;
      mem_req_ready = 1'b1;
      alloc(1'b1, s0);
      alloc(1'b0, l1);
      put_data(s0, 32'h1111_2222);
      put_addr(l1, 16'h0020);
      wait_cyc(6);
      chk("R3 no result while store address unknown", 32'(res_ser[l1] > sb), 0);
      chk("R3 no read while store address unknown", 32'(rd_n - rb), 0);
      put_addr(s0, 16'h0030);
      wait_cyc(8);
      chk("R9 store written", 32'(wr_n - wb), 1);
      chk("R9 store address", 32'(wr_addr[wb]), 32'h0030);
      chk("R4 load after address known", res_dat[l1], init_val(16'h0020));
      chk("R4 load fwd flag", 32'(res_fw[l1]), 0);
      close_case();
   endtask

   task automatic t_forward();
      logic [IW-1:0] s0, l1;
      int rb = rd_n, wb = wr_n, sb = res_n;
      mem_req_ready = 1'b0;
      alloc(1'b1, s0);
      alloc(1'b0, l1);
      put_addr(s0, 16'h0040);
      put_data(s0, 32'hDEAD_0001);
      put_addr(l1, 16'h0040);
      wait_cyc(4);
      chk("R5 forwarded seen", 32'(res_ser[l1] > sb), 1);
      chk("R5 forwarded data", res_dat[l1], 32'hDEAD_0001);
      chk("R5 forward flag", 32'(res_fw[l1]), 1);
      chk("R5 no memory read", 32'(rd_n - rb), 0);
      chk("R9 write held while not ready", 32'({mem_req_valid, mem_req_write}), 32'b11);
      chk("R9 held write address", 32'(mem_req_addr), 32'h0040);
      mem_req_ready = 1'b1;
      wait_cyc(4);
      chk("R9 write after ready", 32'(wr_n - wb), 1);
      close_case();
   endtask

   task automatic t_youngest();
      logic [IW-1:0] s0, s1, s2, l3, l4;
      int rb = rd_n, wb = wr_n;
      mem_req_ready = 1'b0;
      alloc(1'b1, s0); alloc(1'b1, s1); alloc(1'b1, s2);
      alloc(1'b0, l3); alloc(1'b0, l4);
      put_addr(s0, 16'h0050); put_data(s0, 32'hAAAA_0001);
      put_addr(s1, 16'h0050); put_data(s1, 32'hAAAA_0002);
      put_addr(s2, 16'h0060); put_data(s2, 32'hAAAA_0003);
      put_addr(l3, 16'h0050);
      put_addr(l4, 16'h0060);
      wait_cyc(4);
      chk("R6 youngest match data", res_dat[l3], 32'hAAAA_0002);
      chk("R6 youngest match fwd", 32'(res_fw[l3]), 1);
      chk("R5 other address forward", res_dat[l4], 32'hAAAA_0003);
      chk("R5 no reads", 32'(rd_n - rb), 0);
      mem_req_ready = 1'b1;
      wait_cyc(8);
      chk("R9 three writes", 32'(wr_n - wb), 3);
      chk("R9 order first", wr_data[wb], 32'hAAAA_0001);
      chk("R9 order second", wr_data[wb+1], 32'hAAAA_0002);
      chk("R9 order third", wr_data[wb+2], 32'hAAAA_0003);
      chk("R9 back to back", 32'(wr_cyc[wb+2] - wr_cyc[wb]), 2);
      close_case();
   endtask

   task automatic t_late_data();
      logic [IW-1:0] s0, l1;
      int rb = rd_n, sb = res_n;
      mem_req_ready = 1'b0;
      alloc(1'b1, s0);
      alloc(1'b0, l1);
      put_addr(s0, 16'h0070);
      put_addr(l1, 16'h0070);
      wait_cyc(6);
      chk("R7 stalled without data", 32'(res_ser[l1] > sb), 0);
      chk("R7 no read while stalled", 32'(rd_n - rb), 0);
      put_data(s0, 32'hBEEF_0007);
      wait_cyc(3);
      chk("R7 forwarded after data", res_dat[l1], 32'hBEEF_0007);
      chk("R7 forward flag", 32'(res_fw[l1]), 1);
      close_case();
   endtask

   task automatic t_younger_store();
      logic [IW-1:0] l0, s1;
      int wb = wr_n, sb = res_n;
      mem_req_ready = 1'b1;
      alloc(1'b0, l0);
      alloc(1'b1, s1);
      put_addr(s1, 16'h0080);
      put_data(s1, 32'h1234_5678);
      put_addr(l0, 16'h0080);
      wait_cyc(6);
      chk("R8 result seen", 32'(res_ser[l0] > sb), 1);
      chk("R8 younger store ignored", res_dat[l0], init_val(16'h0080));
      chk("R8 not forwarded", 32'(res_fw[l0]), 0);
      chk("R9 store written after load", 32'(wr_n - wb), 1);
      close_case();
   endtask

   task automatic t_independent();
      logic [IW-1:0] l0, s1, l2;
      int wb = wr_n, sb = res_n;
      mem_req_ready = 1'b1;
      alloc(1'b0, l0);
      alloc(1'b1, s1);
      alloc(1'b0, l2);
      put_addr(s1, 16'h0090);
      put_data(s1, 32'h0000_9999);
      put_addr(l2, 16'h00A0);
      wait_cyc(6);
      chk("R4 load passes unwritten store", res_dat[l2], init_val(16'h00A0));
      chk("R4 load seen", 32'(res_ser[l2] > sb), 1);
      chk("R9 store waits for older load", 32'(wr_n - wb), 0);
      put_addr(l0, 16'h00B0);
      wait_cyc(8);
      chk("R4 oldest load", res_dat[l0], init_val(16'h00B0));
      chk("R9 store drained", 32'(wr_n - wb), 1);
      close_case();
   endtask

   task automatic t_full_flush();
      logic [IW-1:0] idx;
      logic [IW-1:0] dummy;
      mem_req_ready = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         alloc(1'b1, idx);
         chk("R2 allocation index", 32'(idx), 32'(i));
      end
      chk("R2 full at depth", 32'(full), 1);
      alloc(1'b1, dummy);
      chk("R2 still full", 32'(full), 1);
      put_addr(0, 16'h00C0);
      put_data(0, 32'h0C0C_0C0C);
      mem_req_ready = 1'b1;
      tick();
      mem_req_ready = 1'b0;
      chk("R2 not full after one drain", 32'(full), 0);
      chk("R2 rejected allocation left index", 32'(alloc_idx), 0);
      put_addr(1, 16'h00C4);
      put_data(1, 32'h0C0C_0C04);
      chk("R11 request before flush", 32'(mem_req_valid), 1);
      do_flush();
      chk("R11 empty after flush", 32'(full), 0);
      chk("R11 index after flush", 32'(alloc_idx), 0);
      chk("R11 no request after flush", 32'(mem_req_valid), 0);
      mem_req_ready = 1'b1;
   endtask

   initial begin
      wait_cyc(4);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_plain_load();
      t_unknown_addr();
      t_forward();
      t_youngest();
      t_late_data();
      t_younger_store();
      t_independent();
      t_full_flush();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule